// File: doc/BRIEF.md
# Fetch PC Window Sequencer

This block sequences instruction-fetch addresses at the head of a processor front end. It holds a window of three program-counter slots: the slot being fetched now (current), the one after it (next), and the one the branch predictor has most recently returned (next-next). Three valid/ready style handshakes surround the window. A predict port asks a branch predictor for the address that follows the next slot. A fetch port hands the current slot, with its per-lane enable vector and tag fields, to the instruction cache. A redirect port restarts the window at a new address, for example after reset or a misprediction.

Only an accepted prediction can fill the next-next slot. The returned enable vector and tag fields belong to the next slot, and they move with it into the current slot. When the current slot is empty and both later slots are full, the window advances by one position in the same cycle. A redirect collapses the window to a single valid next slot and discards any handshake that completes in the same cycle.

Top module: `fetch_pc_window`

## Requirements
- R1: While reset is held and in the first cycle after active-low reset is released, `fch_valid` and `prd_valid` are 0 and `rdr_ready` is 1.
- R2: In the cycle after `rdr_valid` is sampled high, `fch_valid` is 0, `prd_valid` is 1, `prd_cur_pc` equals the redirect address and `prd_cur_ds` is 0.
- R3: Whenever `prd_valid` is 1, `prd_cur_pc` and `prd_cur_ds` show the next slot's address and delay-slot flag. Whenever the current slot is valid, `prd_prev_pc` shows the current slot's address.
- R4: `prd_valid` is 1 exactly when the next slot is valid and the next-next slot is empty, so at most one prediction is outstanding. A stalled prediction keeps `prd_cur_pc` stable.
- R5: An accepted prediction stores the returned PC and delay-slot flag in the next-next slot. The returned enable vector (bit i enables lane i) and tag fields are attached to the next slot and later appear on the fetch port with that address.
- R6: `fch_valid` is 1 exactly when the current slot is valid, and `fch_pc`/`fch_lane_en` show that slot. A fetch handshake empties the current slot. While it is not acknowledged, the presented address holds.
- R7: When the current slot is empty (including just after a fetch handshake) and the next and next-next slots are both valid, the window advances in the same clock edge: next goes to current, next-next goes to next, and next-next is emptied.
- R8: A redirect accepted in the same cycle as a predict or fetch handshake wins. The window holds only the redirect address in the next slot, and the other handshake results are discarded.
- R9: The fetch-pointer (`fch_ptr`), branch-state (`fch_bstate`) and prediction-id (`fch_pid`) fields follow their fetch packet. The pointer and id pass through only when `HAS_PTR`/`HAS_PID` are 1 and read as 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fch_valid | output | 1 | Current slot offered to the instruction cache |
| fch_ready | input | 1 | Cache accepts the fetch packet |
| fch_pc | output | ADDR_W | Fetch address (current slot) |
| fch_lane_en | output | LANES | Per-lane enable of the fetch packet |
| fch_ptr | output | PTR_W | Fetch-pointer tag of the packet |
| fch_bstate | output | BST_W | Branch-state tag of the packet |
| fch_pid | output | PID_W | Prediction-id tag of the packet |
| prd_valid | output | 1 | Prediction request valid |
| prd_ready | input | 1 | Predictor accepts and responds this cycle |
| prd_prev_pc | output | ADDR_W | Current slot address |
| prd_cur_pc | output | ADDR_W | Next slot address |
| prd_cur_ds | output | 1 | Next slot delay-slot-taken flag |
| prd_next_pc | input | ADDR_W | Predicted following address |
| prd_next_ds | input | 1 | Predicted delay-slot-taken flag |
| prd_lane_en | input | LANES | Lane enable for the next slot |
| prd_ptr | input | PTR_W | Fetch-pointer tag for the next slot |
| prd_bstate | input | BST_W | Branch-state tag for the next slot |
| prd_pid | input | PID_W | Prediction-id tag for the next slot |
| rdr_valid | input | 1 | Redirect request |
| rdr_ready | output | 1 | Redirect accepted (always 1) |
| rdr_pc | input | ADDR_W | Redirect address |

## Verification
The bench builds the block with 32-bit addresses, four lanes and both optional tag fields enabled, so pointer and id values reach the fetch port and their pass-through can be compared. A predictor model in the bench returns several enable patterns, and every fifth packet is a taken jump with the delay-slot flag set. Pseudo-random acknowledges on both ports produce stalls, simultaneous handshakes and same-edge advances. Redirects are placed so that some coincide with fetch and predict handshakes.

// File: rtl/fpw_pkg.sv
package fpw_pkg;
    // Occupancy flags of the three-slot window
    typedef struct packed {
        logic cur;
        logic nxt;
        logic nnx;
    } win_occ_t;
endpackage

// File: rtl/fpw_sidefield.sv
module fpw_sidefield #(
    parameter int W  = 2,
    parameter bit EN = 1'b1
) (
    input  logic [W-1:0] in_f,
    output logic [W-1:0] out_f
);
    generate
        if (EN) begin : g_pass
            assign out_f = in_f;
        end else begin : g_zero
            assign out_f = '0;
        end
    endgenerate
endmodule

// File: rtl/fpw_lane_mask.sv
module fpw_lane_mask #(
    parameter int LANES = 4
) (
    output logic [LANES-1:0] mask
);
    // only the lowest lane enabled after a redirect
    assign mask = LANES'(1);
endmodule

// File: rtl/fetch_pc_window.sv
module fetch_pc_window
    import fpw_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int LANES   = 4,
    parameter int PTR_W   = 2,
    parameter int BST_W   = 2,
    parameter int PID_W   = 3,
    parameter bit HAS_PTR = 1'b1,
    parameter bit HAS_PID = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              fch_valid,
    input  logic              fch_ready,
    output logic [ADDR_W-1:0] fch_pc,
    output logic [LANES-1:0]  fch_lane_en,
    output logic [PTR_W-1:0]  fch_ptr,
    output logic [BST_W-1:0]  fch_bstate,
    output logic [PID_W-1:0]  fch_pid,
    output logic              prd_valid,
    input  logic              prd_ready,
    output logic [ADDR_W-1:0] prd_prev_pc,
    output logic [ADDR_W-1:0] prd_cur_pc,
    output logic              prd_cur_ds,
    input  logic [ADDR_W-1:0] prd_next_pc,
    input  logic              prd_next_ds,
    input  logic [LANES-1:0]  prd_lane_en,
    input  logic [PTR_W-1:0]  prd_ptr,
    input  logic [BST_W-1:0]  prd_bstate,
    input  logic [PID_W-1:0]  prd_pid,
    input  logic              rdr_valid,
    output logic              rdr_ready,
    input  logic [ADDR_W-1:0] rdr_pc
);
    localparam int TAG_W = PTR_W + BST_W + PID_W;

    typedef struct packed {
        win_occ_t            occ;
        logic [ADDR_W-1:0]   c_pc;
        logic [LANES-1:0]    c_en;
        logic [TAG_W-1:0]    c_tag;
        logic [ADDR_W-1:0]   n_pc;
        logic                n_ds;
        logic [LANES-1:0]    n_en;
        logic [TAG_W-1:0]    n_tag;
        logic [ADDR_W-1:0]   nn_pc;
        logic                nn_ds;
    } win_st_t;

    win_st_t st_d, st_q;

    logic [PTR_W-1:0] ptr_g;
    logic [PID_W-1:0] pid_g;
    logic [LANES-1:0] first_lane;
    logic             fch_fire, prd_fire;

    fpw_sidefield #(.W(PTR_W), .EN(HAS_PTR)) u_ptr_gate (.in_f(prd_ptr), .out_f(ptr_g));
    fpw_sidefield #(.W(PID_W), .EN(HAS_PID)) u_pid_gate (.in_f(prd_pid), .out_f(pid_g));
    fpw_lane_mask #(.LANES(LANES)) u_first (.mask(first_lane));

    assign rdr_ready   = 1'b1;
    assign fch_valid   = st_q.occ.cur;
    assign fch_pc      = st_q.c_pc;
    assign fch_lane_en = st_q.c_en;
    assign {fch_ptr, fch_bstate, fch_pid} = st_q.c_tag;

    assign prd_valid   = st_q.occ.nxt && !st_q.occ.nnx;
    assign prd_prev_pc = st_q.c_pc;
    assign prd_cur_pc  = st_q.n_pc;
    assign prd_cur_ds  = st_q.n_ds;

    assign fch_fire = fch_valid && fch_ready;
    assign prd_fire = prd_valid && prd_ready;

    always_comb begin
        st_d = st_q;
        if (fch_fire) begin
            st_d.occ.cur = 1'b0;
        end
        if (prd_fire) begin
            st_d.occ.nnx = 1'b1;
            st_d.nn_pc   = prd_next_pc;
            st_d.nn_ds   = prd_next_ds;
            st_d.n_en    = prd_lane_en;
            st_d.n_tag   = {ptr_g, prd_bstate, pid_g};
        end
        if (!st_d.occ.cur && st_d.occ.nxt && st_d.occ.nnx) begin
            st_d.occ.cur = 1'b1;
            st_d.c_pc    = st_d.n_pc;
            st_d.c_en    = st_d.n_en;
            st_d.c_tag   = st_d.n_tag;
            st_d.n_pc    = st_d.nn_pc;
            st_d.n_ds    = st_d.nn_ds;
            st_d.occ.nnx = 1'b0;
        end
        if (rdr_valid) begin
            st_d.occ   = '{cur: 1'b0, nxt: 1'b1, nnx: 1'b0};
            st_d.n_pc  = rdr_pc;
            st_d.n_ds  = 1'b0;
            st_d.n_en  = first_lane;
            st_d.n_tag = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R6
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fch_valid && !fch_ready && !rdr_valid |=> fch_valid && $stable(fch_pc) && $stable(fch_lane_en));

    // R2
    redirect_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rdr_valid |=> !fch_valid && prd_valid && prd_cur_pc == $past(rdr_pc) && !prd_cur_ds);

    // R5
    predict_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prd_valid && prd_ready && !rdr_valid && (!fch_valid || fch_ready)
        |=> fch_valid && fch_pc == $past(prd_cur_pc) && fch_lane_en == $past(prd_lane_en));

    // R4
    predict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prd_valid && !prd_ready && !rdr_valid |=> prd_valid && $stable(prd_cur_pc) && $stable(prd_cur_ds));

    // R1
    redirect_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !fch_valid && !prd_valid);
endmodule

// File: tb/tb_fetch_pc_window.sv
`timescale 1ns/1ps
module tb_fetch_pc_window;
    localparam int A = 32, L = 4, P = 2, B = 2, I = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic fch_valid, fch_ready, prd_valid, prd_ready, prd_cur_ds, prd_next_ds, rdr_valid, rdr_ready;
    logic [A-1:0] fch_pc, prd_prev_pc, prd_cur_pc, prd_next_pc, rdr_pc;
    logic [L-1:0] fch_lane_en, prd_lane_en;
    logic [P-1:0] fch_ptr, prd_ptr;
    logic [B-1:0] fch_bstate, prd_bstate;
    logic [I-1:0] fch_pid, prd_pid;

    fetch_pc_window #(.ADDR_W(A), .LANES(L), .PTR_W(P), .BST_W(B), .PID_W(I)) dut (
        .clk(clk), .rst_n(rst_n),
        .fch_valid(fch_valid), .fch_ready(fch_ready), .fch_pc(fch_pc), .fch_lane_en(fch_lane_en),
        .fch_ptr(fch_ptr), .fch_bstate(fch_bstate), .fch_pid(fch_pid),
        .prd_valid(prd_valid), .prd_ready(prd_ready), .prd_prev_pc(prd_prev_pc),
        .prd_cur_pc(prd_cur_pc), .prd_cur_ds(prd_cur_ds), .prd_next_pc(prd_next_pc),
        .prd_next_ds(prd_next_ds), .prd_lane_en(prd_lane_en), .prd_ptr(prd_ptr),
        .prd_bstate(prd_bstate), .prd_pid(prd_pid),
        .rdr_valid(rdr_valid), .rdr_ready(rdr_ready), .rdr_pc(rdr_pc));

    typedef struct {
        logic [A-1:0] pc;
        logic [L-1:0] en;
        logic [P-1:0] ptr;
        logic [B-1:0] bst;
        logic [I-1:0] pid;
    } pkt_t;

    pkt_t sb_q[$];
    int checks = 0, errors = 0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // reference window
    logic m_cv, m_nv, m_nnv, m_nds, m_nnds;
    logic [A-1:0] m_cpc, m_npc, m_nnpc;
    pkt_t m_nside;
    int pkt_no;
    logic [15:0] lfsr = 16'hACE1;

    // monitor: compare each completed fetch with the scoreboard head
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && fch_valid && fch_ready && !rdr_valid) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected fetch", 64'(fch_pc), 64'hFFFF);
                end else begin
                    pkt_t e;
                    e = sb_q.pop_front();
                    chk(fch_pc == e.pc, "R6 fetch pc", 64'(fch_pc), 64'(e.pc));
                    chk(fch_lane_en == e.en, "R5 lane enable", 64'(fch_lane_en), 64'(e.en));
                    chk(fch_ptr == e.ptr && fch_pid == e.pid, "R9 ptr/pid tags",
                        64'({fch_ptr, fch_pid}), 64'({e.ptr, e.pid}));
                    chk(fch_bstate == e.bst, "R9 branch state", 64'(fch_bstate), 64'(e.bst));
                end
            end
        end
    end

    // driver: stimulus plus reference model, pushes expected packets
    initial begin
        fch_ready = 0; prd_ready = 0; rdr_valid = 0; rdr_pc = '0;
        prd_next_pc = '0; prd_next_ds = 0; prd_lane_en = '0;
        prd_ptr = '0; prd_bstate = '0; prd_pid = '0;
        m_cv = 0; m_nv = 0; m_nnv = 0; m_nds = 0; m_nnds = 0;
        m_cpc = '0; m_npc = '0; m_nnpc = '0; m_nside = '{default: '0}; pkt_no = 1;
        repeat (3) @(posedge clk);
        #1;
        chk(!fch_valid && !prd_valid && rdr_ready, "R1 in reset", 64'({fch_valid, prd_valid, rdr_ready}), 64'h1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!fch_valid && !prd_valid && rdr_ready, "R1 after release",
            64'({fch_valid, prd_valid, rdr_ready}), 64'h1);
        for (int cyc = 0; cyc < 400; cyc++) begin
            logic pf, af, take, last_ev;
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            fch_ready = lfsr[0] | lfsr[3];
            prd_ready = lfsr[5] | lfsr[8];
            last_ev   = rdr_valid;
            rdr_valid = (cyc == 0) || (cyc == 90) || (cyc == 91) || (cyc == 200) || (cyc == 310 && m_cv);
            if (cyc == 310) fch_ready = 1'b1;
            rdr_pc    = (cyc == 0) ? 32'h100 : 32'h2000 + 32'(cyc * 16);
            take        = (pkt_no % 5) == 0;
            prd_next_pc = take ? m_npc + 32'h100 : m_npc + 32'h10;
            prd_next_ds = take;
            prd_lane_en = (pkt_no % 3 == 0) ? 4'b1111 : (4'b0011 << (pkt_no % 3));
            prd_ptr     = 2'(pkt_no);
            prd_bstate  = 2'(pkt_no >> 1);
            prd_pid     = 3'(pkt_no + 3);
            #1;
            // R7 / R8: fetch valid follows the window occupancy
            chk(fch_valid == m_cv, last_ev ? "R8 fetch valid after redirect" : "R7 fetch valid",
                64'(fch_valid), 64'(m_cv));
            if (m_cv) chk(fch_pc == m_cpc, "R6 fetch pc shown", 64'(fch_pc), 64'(m_cpc));
            chk(prd_valid == (m_nv && !m_nnv), "R4 predict valid", 64'(prd_valid), 64'(m_nv && !m_nnv));
            if (m_nv) begin
                chk(prd_cur_pc == m_npc, last_ev ? "R2 redirect pc" : "R3 predict cur pc",
                    64'(prd_cur_pc), 64'(m_npc));
                chk(prd_cur_ds == m_nds, last_ev ? "R2 redirect ds" : "R3 predict cur ds",
                    64'(prd_cur_ds), 64'(m_nds));
            end
            if (m_cv) chk(prd_prev_pc == m_cpc, "R3 predict prev pc", 64'(prd_prev_pc), 64'(m_cpc));
            // model update
            af = m_cv && fch_ready;
            pf = m_nv && !m_nnv && prd_ready;
            if (af) begin
                m_cv = 0;
                pkt_no++;
            end
            if (pf) begin
                m_nnv = 1; m_nnpc = prd_next_pc; m_nnds = prd_next_ds;
                m_nside.en = prd_lane_en; m_nside.ptr = prd_ptr;
                m_nside.bst = prd_bstate; m_nside.pid = prd_pid;
            end
            if (!m_cv && m_nv && m_nnv) begin
                m_cv = 1; m_cpc = m_npc;
                m_nside.pc = m_npc;
                sb_q.push_back(m_nside);
                m_npc = m_nnpc; m_nds = m_nnds; m_nnv = 0;
            end
            if (rdr_valid) begin
                m_cv = 0; m_nnv = 0; m_nv = 1; m_npc = rdr_pc; m_nds = 0;
                m_nside = '{default: '0};
                sb_q.delete();
            end
        end
        @(negedge clk);
        rdr_valid = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #20000;
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule